// File: doc/BRIEF.md
# Serial ADC Device-Side Interface

This block is the digital face of an eight-input, 12-bit sampling converter seen from the device side of a four-wire serial link. A host lowers the chip select, clocks a control byte in on the data input, and reads the conversion result back on the data output while a busy flag marks the hold instant. The analog path is replaced by two parallel sample buses. One carries a 12-bit word per single-ended channel and the other a 12-bit word per differential pairing. The word picked by the control byte is latched at the moment the block enters hold.

All pins are sampled by one fast system clock. The serial clock, chip select, data input and shutdown are treated as synchronous inputs, and edges of the serial clock are found by comparing against the previous sample. The high and low phases of the serial clock must each last at least two system clocks. The receiver that hunts for the start bit runs independently of the sequencer that shifts out the result. A new control byte can therefore arrive while the previous result is still leaving, which gives one conversion every 16 or 15 serial clocks. The output and busy drivers come with separate enables for the pad tri-states. A power indicator models the auto power-down and always-on modes.

Top module: `adc_serial_if`

## Requirements
- R1: The data input is taken only on a rising serial-clock edge while chip select is low. Chip select high aborts any partial control byte and any result in progress, and the receiver resumes hunting for a start bit.
- R2: `dout_oe` and `busy_oe` are low whenever `cs_n` is high, and high whenever it is low.
- R3: Zeros on the data input are skipped while hunting. The first 1 is the start bit. The seven bits that follow are, in order, A2, A1, A0, one unused bit, SGL, PD1 and PD0.
- R4: After the A0 bit, `acquiring` rises and `mux_pos` shows the +IN channel {A1,A0,A2}. Code 100 therefore selects channel 1 and code 011 selects channel 6. `acquiring` falls after the PD0 bit.
- R5: At the PD0 bit the result is latched from `se_samples` word `mux_pos` when SGL=1, or from `df_samples` word `mux_pos` when SGL=0. Word i sits at bits [12i+11:12i]. Later changes of the sample buses do not alter that result, and codes 000h and FFFh pass through unchanged as straight binary. `mux_se` shows SGL once the byte is complete.
- R6: `busy` goes high on the falling serial edge that follows the PD0 rising edge and stays high for exactly one serial-clock period.
- R7: The 12 result bits leave MSB first, one per falling edge, starting with the falling edge that ends busy. `dout` changes only on falling edges or when the block is cleared.
- R8: After the LSB, `dout` stays low for every further clock of the transfer.
- R9: A start bit is accepted on any rising edge after PD0, including while a result is shifting out. Back-to-back conversions on 16-clock and 15-clock spacing both return correct results.
- R10: With PD1:PD0 = 11, `powered` stays high between conversions. With 00, or with the reserved codes 01 and 10, `powered` is high only from the A0 bit until the falling edge after the LSB.
- R11: With `shdn_n` low, `powered` is low, any partial byte or result in progress is dropped, and the always-on setting is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| dclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial control data |
| shdn_n | input | 1 | Shutdown, active low |
| se_samples | input | 8*RES | Single-ended sample word per channel |
| df_samples | input | 8*RES | Differential sample word per pairing code |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Tri-state enable for dout |
| busy | output | 1 | Busy flag at hold |
| busy_oe | output | 1 | Tri-state enable for busy |
| mux_pos | output | 3 | +IN channel selected |
| mux_se | output | 1 | Single-ended (1) or differential (0) mode of the last byte |
| acquiring | output | 1 | Acquisition window active |
| powered | output | 1 | Converter power indicator |

## Verification
A receiver bit counter that is off by one shows up within the same byte. `acquiring` rises one serial clock early or late, the busy pulse moves, and every result bit after it is shifted by one position, so the returned word is wrong before the byte completes. A sequencer phase error shows up within 13 falling edges: either busy lasts two periods, or the word is truncated, or nonzero bits trail after the LSB. A missed clear on chip select or shutdown surfaces on the next transfer, because the leftover partial byte consumes the host's bits and returns the wrong channel. Power-mode errors appear one falling edge after the LSB, when `powered` fails to drop or fails to stay high.

// File: rtl/adcsi_pkg.sv
package adcsi_pkg;
  // Serial control byte length, fixed by the protocol
  localparam int CTRL_BITS = 8;
  // Number of analog inputs addressed by the three address bits
  localparam int NUM_CH = 8;
  localparam int SELW = $clog2(NUM_CH);

  typedef enum logic [1:0] {
    PWR_AUTO  = 2'b00,
    PWR_RSV_A = 2'b01,
    PWR_RSV_B = 2'b10,
    PWR_ON    = 2'b11
  } pwr_mode_e;

  // +IN channel for an address code: bits rotate so A2 becomes the LSB
  function automatic logic [SELW-1:0] pos_of(input logic [2:0] a);
    return {a[1], a[0], a[2]};
  endfunction

  // Only the all-ones code keeps the converter awake; reserved codes act as auto
  function automatic logic keeps_power(input logic [1:0] pd);
    return pwr_mode_e'(pd) == PWR_ON;
  endfunction
endpackage

// File: rtl/adcsi_ctl_rx.sv
module adcsi_ctl_rx
  import adcsi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       rise,
  input  logic       din,
  output logic       hunting,
  output logic       addr_hit,
  output logic [2:0] addr,
  output logic       done,
  output logic       sgl,
  output logic [1:0] pd
);
  localparam int CW = $clog2(CTRL_BITS);

  logic [CW-1:0]        cnt;
  logic [CTRL_BITS-2:0] sr;

  assign hunting = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      sr       <= '0;
      addr_hit <= 1'b0;
      addr     <= '0;
      done     <= 1'b0;
      sgl      <= 1'b0;
      pd       <= '0;
    end else begin
      addr_hit <= 1'b0;
      done     <= 1'b0;
      if (clr) begin
        cnt <= '0;
        sr  <= '0;
      end else if (rise) begin
        if (cnt == '0) begin
          if (din) cnt <= CW'(1);
        end else begin
          sr <= {sr[CTRL_BITS-3:0], din};
          if (cnt == CW'(3)) begin
            addr_hit <= 1'b1;
            addr     <= {sr[1:0], din};
          end
          if (cnt == CW'(CTRL_BITS-1)) begin
            done <= 1'b1;
            sgl  <= sr[1];
            pd   <= {sr[0], din};
            cnt  <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/adcsi_res_tx.sv
module adcsi_res_tx #(
  parameter int RES = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           fall,
  input  logic           load,
  input  logic [RES-1:0] sample,
  output logic           dout,
  output logic           busy,
  output logic           active
);
  // phase 0 idle, 1 armed, 2..RES+1 data bits, RES+2 trailing zero
  localparam int PW = $clog2(RES + 3);
  localparam logic [PW-1:0] PH_LAST = PW'(RES + 1);
  localparam logic [PW-1:0] PH_TAIL = PW'(RES + 2);

  logic [PW-1:0]  ph;
  logic [RES-1:0] data;

  assign active = (ph != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= '0;
      data <= '0;
      dout <= 1'b0;
      busy <= 1'b0;
    end else if (clr) begin
      ph   <= '0;
      dout <= 1'b0;
      busy <= 1'b0;
    end else if (load) begin
      data <= sample;
      ph   <= PW'(1);
    end else if (fall) begin
      if (ph == PW'(1)) begin
        busy <= 1'b1;
        dout <= 1'b0;
        ph   <= PW'(2);
      end else if (ph >= PW'(2) && ph <= PH_LAST) begin
        busy <= 1'b0;
        dout <= data[RES-1];
        data <= {data[RES-2:0], 1'b0};
        ph   <= ph + PW'(1);
      end else begin
        busy <= 1'b0;
        dout <= 1'b0;
        if (ph == PH_TAIL) ph <= '0;
      end
    end
  end
endmodule

// File: rtl/adc_serial_if.sv
module adc_serial_if
  import adcsi_pkg::*;
#(
  parameter int RES = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  dclk,
  input  logic                  din,
  input  logic                  shdn_n,
  input  logic [NUM_CH*RES-1:0] se_samples,
  input  logic [NUM_CH*RES-1:0] df_samples,
  output logic                  dout,
  output logic                  dout_oe,
  output logic                  busy,
  output logic                  busy_oe,
  output logic [SELW-1:0]       mux_pos,
  output logic                  mux_se,
  output logic                  acquiring,
  output logic                  powered
);
  logic dclk_q;
  logic rise_evt, fall_evt, clr;
  logic rx_hunting, addr_hit, byte_done, byte_sgl;
  logic [2:0] addr;
  logic [1:0] byte_pd;
  logic seq_active, aon_q;
  logic [RES-1:0] se_w [NUM_CH];
  logic [RES-1:0] df_w [NUM_CH];
  logic [RES-1:0] hold_word;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign se_w[g] = se_samples[g*RES +: RES];
    assign df_w[g] = df_samples[g*RES +: RES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dclk_q <= 1'b0;
    else        dclk_q <= dclk;
  end

  assign rise_evt = !cs_n && dclk && !dclk_q;
  assign fall_evt = !cs_n && !dclk && dclk_q;
  assign clr      = cs_n || !shdn_n;

  adcsi_ctl_rx u_rx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .rise(rise_evt), .din(din),
    .hunting(rx_hunting), .addr_hit(addr_hit), .addr(addr),
    .done(byte_done), .sgl(byte_sgl), .pd(byte_pd)
  );

  assign hold_word = byte_sgl ? se_w[mux_pos] : df_w[mux_pos];

  adcsi_res_tx #(.RES(RES)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .fall(fall_evt), .load(byte_done),
    .sample(hold_word), .dout(dout), .busy(busy), .active(seq_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_pos   <= '0;
      mux_se    <= 1'b0;
      acquiring <= 1'b0;
      aon_q     <= 1'b0;
    end else begin
      if (clr) begin
        acquiring <= 1'b0;
      end else if (addr_hit) begin
        mux_pos   <= pos_of(addr);
        acquiring <= 1'b1;
      end else if (byte_done) begin
        acquiring <= 1'b0;
        mux_se    <= byte_sgl;
        aon_q     <= keeps_power(byte_pd);
      end
      if (!shdn_n) aon_q <= 1'b0;
    end
  end

  assign dout_oe = !cs_n;
  assign busy_oe = !cs_n;
  assign powered = shdn_n && (aon_q || acquiring || seq_active);
endmodule

// File: rtl/adcsi_chk.sv
module adcsi_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic shdn_n,
  input logic dout,
  input logic busy,
  input logic powered,
  input logic acquiring,
  input logic fall_evt,
  input logic byte_done,
  input logic rx_hunting
);
  assert_cs_clears_rx_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> rx_hunting);

  assert_acq_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !acquiring);

  assert_busy_one_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fall_evt) |=> !busy);

  assert_dout_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> ($past(fall_evt) || $past(cs_n) || !$past(shdn_n)));

  assert_busy_powered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> powered);

  assert_shdn_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> (!acquiring && !busy && !powered));
endmodule

bind adc_serial_if adcsi_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .shdn_n(shdn_n), .dout(dout),
  .busy(busy), .powered(powered), .acquiring(acquiring), .fall_evt(fall_evt),
  .byte_done(byte_done), .rx_hunting(rx_hunting)
);

// File: tb/adc_serial_if_tb.sv
module adc_serial_if_tb;
  localparam int RES = 12;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, dclk = 1'b0, din = 1'b0, shdn_n = 1'b1;
  logic [NCH*RES-1:0] se_samples, df_samples;
  logic dout, dout_oe, busy, busy_oe, mux_se, acquiring, powered;
  logic [2:0] mux_pos;

  int n_chk = 0;
  int n_fail = 0;

  logic lg_dout [0:63];
  logic lg_busy [0:63];
  logic lg_pwr  [0:63];
  logic lg_acq  [0:63];
  logic [2:0] lg_pos [0:63];
  int   lg_n = 0;

  always #2 clk = ~clk;

  adc_serial_if #(.RES(RES)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dclk(dclk), .din(din),
    .shdn_n(shdn_n), .se_samples(se_samples), .df_samples(df_samples),
    .dout(dout), .dout_oe(dout_oe), .busy(busy), .busy_oe(busy_oe),
    .mux_pos(mux_pos), .mux_se(mux_se), .acquiring(acquiring), .powered(powered)
  );

  function automatic logic [7:0] ctl(input logic [2:0] a, input logic s, input logic [1:0] p);
    return {1'b1, a, 1'b0, s, p};
  endfunction

  function automatic logic [11:0] se_val(input int i);
    if (i == 0) return 12'h000;
    if (i == 7) return 12'hFFF;
    return 12'(12'h1A3 + i * 12'h211);
  endfunction

  function automatic logic [11:0] df_val(input int i);
    return 12'(12'h5C0 ^ (i * 12'h0F3 + 12'h017));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_samples();
    for (int i = 0; i < NCH; i++) begin
      se_samples[i*RES +: RES] = se_val(i);
      df_samples[i*RES +: RES] = df_val(i);
    end
  endtask

  // One serial-clock period: 2 system clocks high, 2 low, sampled after the fall
  task automatic dbit(input logic b);
    @(negedge clk); din = b; dclk = 1'b1;
    @(negedge clk);
    @(negedge clk); dclk = 1'b0;
    @(negedge clk);
    if (lg_n < 64) begin
      lg_dout[lg_n] = dout;
      lg_busy[lg_n] = busy;
      lg_pwr[lg_n]  = powered;
      lg_acq[lg_n]  = acquiring;
      lg_pos[lg_n]  = mux_pos;
    end
    lg_n++;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) dbit(b[i]);
  endtask

  task automatic zeros(input int k);
    for (int i = 0; i < k; i++) dbit(1'b0);
  endtask

  task automatic start_xfer();
    lg_n = 0;
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic end_xfer();
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
  endtask

  // e = index of the period holding the PD0 bit
  task automatic check_result(input string req, input int e, input logic [11:0] val);
    logic [11:0] got;
    for (int k = 0; k < 12; k++) got[11-k] = lg_dout[e+1+k];
    check({req, " busy before hold"}, 32'(lg_busy[e-1]), 32'd0);
    check({req, " busy at hold"}, 32'(lg_busy[e]), 32'd1);
    check({req, " busy one period"}, 32'(lg_busy[e+1]), 32'd0);
    check({req, " result word"}, 32'(got), 32'(val));
  endtask

  task automatic t_reset();
    check("R2 dout_oe at reset", 32'(dout_oe), 32'd0);
    check("R2 busy_oe at reset", 32'(busy_oe), 32'd0);
    check("R10 powered at reset", 32'(powered), 32'd0);
    check("R7 dout at reset", 32'(dout), 32'd0);
  endtask

  task automatic t_single();
    start_xfer();
    check("R2 dout_oe with cs low", 32'(dout_oe), 32'd1);
    check("R2 busy_oe with cs low", 32'(busy_oe), 32'd1);
    send_byte(ctl(3'b100, 1'b1, 2'b00));
    zeros(16);
    check("R4 not acquiring before A0", 32'(lg_acq[2]), 32'd0);
    check("R4 acquiring after A0", 32'(lg_acq[3]), 32'd1);
    check("R4 mux_pos code 100", 32'(lg_pos[3]), 32'd1);
    check("R4 acquiring ends at PD0", 32'(lg_acq[7]), 32'd0);
    check_result("R5 R6 R7 single ch1", 7, se_val(1));
    check("R5 mux_se single", 32'(mux_se), 32'd1);
    for (int i = 20; i < 24; i++) check("R8 trailing zero", 32'(lg_dout[i]), 32'd0);
    check("R10 auto power before address", 32'(lg_pwr[0]), 32'd0);
    check("R10 auto power at LSB", 32'(lg_pwr[19]), 32'd1);
    check("R10 auto power off after LSB", 32'(lg_pwr[20]), 32'd0);
    end_xfer();
    start_xfer();
    send_byte(ctl(3'b011, 1'b1, 2'b11));
    zeros(16);
    check("R4 mux_pos code 011", 32'(lg_pos[4]), 32'd6);
    check_result("R5 R7 single ch6", 7, se_val(6));
    check("R10 always-on stays powered", 32'(lg_pwr[23]), 32'd1);
    end_xfer();
    check("R10 always-on with cs high", 32'(powered), 32'd1);
    start_xfer();
    send_byte(ctl(3'b001, 1'b1, 2'b01));
    zeros(16);
    check_result("R5 single ch2", 7, se_val(2));
    check("R10 reserved code powers down", 32'(lg_pwr[21]), 32'd0);
    end_xfer();
  endtask

  task automatic t_diff();
    start_xfer();
    send_byte(ctl(3'b101, 1'b0, 2'b00));
    zeros(16);
    check("R4 mux_pos diff 101", 32'(lg_pos[5]), 32'd3);
    check_result("R5 diff pair 101", 7, df_val(3));
    check("R5 mux_se diff", 32'(mux_se), 32'd0);
    end_xfer();
  endtask

  task automatic t_hunt();
    start_xfer();
    zeros(5);
    send_byte(ctl(3'b110, 1'b1, 2'b00));
    zeros(16);
    check("R3 no acquire while hunting", 32'(lg_acq[7]), 32'd0);
    check("R3 acquire after late start", 32'(lg_acq[8]), 32'd1);
    check_result("R3 hunted start ch5", 12, se_val(5));
    end_xfer();
  endtask

  task automatic t_hold();
    start_xfer();
    send_byte(ctl(3'b000, 1'b1, 2'b00));
    se_samples[0 +: RES] = 12'hA5A;
    zeros(16);
    check_result("R5 change after hold ignored", 7, 12'h000);
    end_xfer();
    start_xfer();
    for (int i = 7; i >= 3; i--) dbit(ctl(3'b000, 1'b1, 2'b00)[i]);
    se_samples[0 +: RES] = 12'h3C7;
    for (int i = 2; i >= 0; i--) dbit(ctl(3'b000, 1'b1, 2'b00)[i]);
    zeros(16);
    check_result("R5 change during acquire taken", 7, 12'h3C7);
    end_xfer();
    load_samples();
  endtask

  task automatic t_overlap(input int gap, input string tag);
    start_xfer();
    send_byte(ctl(3'b000, 1'b1, 2'b00));
    zeros(gap);
    send_byte(ctl(3'b111, 1'b1, 2'b00));
    zeros(16);
    check_result({tag, " first word 000h"}, 7, se_val(0));
    check_result({tag, " second word FFFh"}, 7 + 8 + gap, se_val(7));
    check({tag, " zero after second LSB"}, 32'(lg_dout[7 + 8 + gap + 13]), 32'd0);
    end_xfer();
  endtask

  task automatic t_cs_abort();
    start_xfer();
    dbit(1'b1); dbit(1'b1); dbit(1'b1); dbit(1'b1);
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    check("R2 dout_oe off with cs high", 32'(dout_oe), 32'd0);
    check("R2 busy_oe off with cs high", 32'(busy_oe), 32'd0);
    dbit(1'b1); dbit(1'b1); dbit(1'b0); dbit(1'b1);
    lg_n = 0;
    @(negedge clk); cs_n = 1'b0;
    send_byte(ctl(3'b010, 1'b1, 2'b00));
    zeros(16);
    check_result("R1 partial byte discarded ch4", 7, se_val(4));
    end_xfer();
  endtask

  task automatic t_shdn();
    start_xfer();
    send_byte(ctl(3'b001, 1'b1, 2'b11));
    zeros(16);
    check("R10 always-on before shutdown", 32'(powered), 32'd1);
    dbit(1'b1); dbit(1'b1); dbit(1'b1);
    @(negedge clk); shdn_n = 1'b0;
    @(negedge clk);
    check("R11 powered low in shutdown", 32'(powered), 32'd0);
    @(negedge clk); shdn_n = 1'b1;
    @(negedge clk);
    check("R11 always-on cleared", 32'(powered), 32'd0);
    lg_n = 0;
    send_byte(ctl(3'b101, 1'b1, 2'b00));
    zeros(16);
    check_result("R11 partial byte dropped ch3", 7, se_val(3));
    end_xfer();
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    load_samples();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single();
    t_diff();
    t_hunt();
    t_hold();
    t_overlap(8, "R9 16-clock");
    t_overlap(7, "R9 15-clock");
    t_cs_abort();
    t_shdn();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule